// File: doc/BRIEF.md
# Multi-core reset and boot sequencer

This block is a register-mapped controller that starts, stops and resets up to four processor cores and resets two auxiliary display units. Software reaches it over a simple 32-bit register port. A register index is the byte address divided by four, and the block occupies a 4 KB window. Sixteen registers are implemented: a control register at index 0, status and mask words, and ten general-purpose boot words at indices 6 to 15.

A write to the control register is compared bit by bit with the old contents, and only bits that change cause actions. Turning on a core's enable latches that core's entry address and argument from its own pair of boot words. Toggling a core's reset bit sends a one-cycle reset pulse to that core. In both cases the core's reset bit stays as written until the core acknowledges the action, and then it clears itself. Each core has its own sequencer with three states:

- `SEQ_IDLE`: no action is outstanding.
- `SEQ_WAIT`: an action has been issued and the sequencer waits for the acknowledge.
- `SEQ_WAIT_PEND`: the sequencer is waiting, and one more reset request is queued.

The transitions are named as follows:

- *issue*: `SEQ_IDLE` to `SEQ_WAIT`, taken on any request. A reset request also pulses the core's reset.
- *retire*: `SEQ_WAIT` to `SEQ_IDLE`, taken on an acknowledge with no new request. It clears the core's reset bit.
- *chain*: stays in `SEQ_WAIT`, taken on an acknowledge that arrives together with a new request. A reset request in that cycle pulses the reset at once.
- *defer*: `SEQ_WAIT` to `SEQ_WAIT_PEND`, taken on a reset request that arrives with no acknowledge.
- *replay*: `SEQ_WAIT_PEND` to `SEQ_WAIT`, taken on an acknowledge. It issues the queued reset pulse.

Top module: `rbc_top`

## Requirements
- R1: After reset, index 0 reads 0x521, index 2 reads 0x1, index 4 reads 0x1F, and every other index from 0 to 15 reads 0.
- R2: A write to any index from 1 to 15 stores the data unchanged, and a read at byte address 4*i returns it at once, combinationally.
- R3: An access with sel high that is out of range (index 16 or above) or misaligned (byte address bits 1:0 not zero) raises bus_err for exactly the next cycle and leaves every register unchanged. An out-of-range read returns 0.
- R4: Writing 1 to control bit 3 or control bit 12 pulses aux_rst[0] or aux_rst[1], respectively, for one cycle after the write. Neither bit is ever stored, so both always read 0.
- R5: When control bit 21+k (core k = 1..3) changes from 0 to 1, core_en[k] goes high after the write. core_boot_addr for core k is latched from index 6+2k and core_boot_arg from index 7+2k, and both hold when those words change later.
- R6: When control bit 21+k changes from 1 to 0, core_en[k] goes low after the write, and no reset pulse is issued for that change.
- R7: A change of control bit 13+k (core k = 0..3) on a control write to an idle core pulses core_rst[k] for one cycle after the write.
- R8: After an enable change or a reset request, control bit 13+k keeps its written value until core_ack[k] is sampled high, and reads 0 from the cycle after that. An acknowledge to an idle core has no effect.
- R9: A reset-bit change for a core that is still waiting for its acknowledge produces no pulse at first. The pulse appears in the cycle after that acknowledge, and the reset bit is cleared only on the acknowledge that follows.
- R10: core_en[0] is always 1. Every control bit not named in R4 to R8 is plain storage and triggers no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | Write enable, qualified by bus_sel |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| bus_err | output | 1 | One-cycle error for a bad access |
| core_ack | input | 4 | Per-core action-complete acknowledge |
| core_en | output | 4 | Per-core enable |
| core_rst | output | 4 | Per-core one-cycle reset pulse |
| core_boot_addr | output | 128 | Latched entry address, 32 bits per core, core 0 at bits 31:0 |
| core_boot_arg | output | 128 | Latched entry argument, 32 bits per core |
| aux_rst | output | 2 | Auxiliary unit reset pulses |

## Verification
The bench sweeps every register index for reset values and readback. It also probes indices just past the end, at the top of the window and at misaligned addresses. A design that decoded the index wrongly or let a bad write through would corrupt a boot word or fail to raise the error. Every core is walked through a reset request held across idle cycles before its acknowledge; a design that cleared the bit in the same cycle would read 0 too early. Reset requests that arrive during a wait are checked for a missing or early pulse, and boot words are rewritten after a core starts to catch a design that forwards them instead of latching them.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE      = 2'd0,
        SEQ_WAIT      = 2'd1,
        SEQ_WAIT_PEND = 2'd2
    } seq_state_t;

endpackage

// File: rtl/rbc_regfile.sv
module rbc_regfile #(
    parameter int DW       = 32,
    parameter int AW       = 12,
    parameter int NREGS    = 16,
    parameter int NCORES   = 4,
    parameter int RST_LSB  = 13,
    parameter int EN_LSB   = 22,
    parameter int AUX0_BIT = 3,
    parameter int AUX1_BIT = 12,
    parameter int STAT_IDX = 2,
    parameter int MASK_IDX = 4,
    parameter int GP_BASE  = 6,
    parameter logic [31:0] CTRL_INIT = 32'h0000_0521,
    parameter logic [31:0] STAT_INIT = 32'h0000_0001,
    parameter logic [31:0] MASK_INIT = 32'h0000_001F
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [AW-1:0]        bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    output logic                 bus_err,
    input  logic [NCORES-1:0]    rst_clr,
    output logic [NCORES-1:0]    rst_chg,
    output logic [NCORES-1:0]    en_chg,
    output logic [NCORES-1:0]    en_wval,
    output logic [NCORES-1:0]    en_q,
    output logic [NCORES*DW-1:0] src_addr,
    output logic [NCORES*DW-1:0] src_arg,
    output logic [1:0]           aux_pulse
);
    localparam int IW   = AW - 2;
    localparam int IDXB = $clog2(NREGS);

    logic [DW-1:0]   regs [NREGS];
    logic [IW-1:0]   idx;
    logic [IDXB-1:0] idx_s;
    logic            aligned;
    logic            in_range;
    logic            good_wr;
    logic            ctrl_wr;
    logic [DW-1:0]   ctrl_next;
    logic [DW-1:0]   aux_mask;

    assign idx      = bus_addr[AW-1:2];
    assign idx_s    = idx[IDXB-1:0];
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign in_range = (32'(idx) < NREGS);
    assign good_wr  = bus_sel && bus_wr && aligned && in_range;
    assign ctrl_wr  = good_wr && (idx == '0);
    assign aux_mask = (DW'(1) << AUX0_BIT) | (DW'(1) << AUX1_BIT);

    assign bus_rdata = in_range ? regs[idx_s] : '0;

    always_comb begin
        ctrl_next = ctrl_wr ? (bus_wdata & ~aux_mask) : regs[0];
        for (int k = 0; k < NCORES; k++) begin
            if (rst_clr[k]) ctrl_next[RST_LSB+k] = 1'b0;
        end
    end

    generate
        for (genvar k = 0; k < NCORES; k++) begin : g_core
            assign rst_chg[k] = ctrl_wr && (regs[0][RST_LSB+k] != bus_wdata[RST_LSB+k]);
            if (k == 0) begin : g_boot_core
                assign en_chg[k]  = 1'b0;
                assign en_wval[k] = 1'b1;
                assign en_q[k]    = 1'b1;
                assign src_addr[k*DW +: DW] = '0;
                assign src_arg[k*DW +: DW]  = '0;
            end else begin : g_sec_core
                assign en_chg[k]  = ctrl_wr && (regs[0][EN_LSB+k-1] != bus_wdata[EN_LSB+k-1]);
                assign en_wval[k] = bus_wdata[EN_LSB+k-1];
                assign en_q[k]    = regs[0][EN_LSB+k-1];
                assign src_addr[k*DW +: DW] = regs[GP_BASE+2*k];
                assign src_arg[k*DW +: DW]  = regs[GP_BASE+2*k+1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
            regs[0]        <= CTRL_INIT;
            regs[STAT_IDX] <= STAT_INIT;
            regs[MASK_IDX] <= MASK_INIT;
            bus_err        <= 1'b0;
            aux_pulse      <= '0;
        end else begin
            bus_err   <= bus_sel && !(aligned && in_range);
            aux_pulse <= {ctrl_wr && bus_wdata[AUX1_BIT], ctrl_wr && bus_wdata[AUX0_BIT]};
            regs[0]   <= ctrl_next;
            if (good_wr && (idx != '0)) regs[idx_s] <= bus_wdata;
        end
    end

endmodule

// File: rtl/rbc_core_seq.sv
module rbc_core_seq
    import rbc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_rst,
    input  logic          req_pwr,
    input  logic          pwr_on,
    input  logic          ack,
    input  logic [DW-1:0] addr_src,
    input  logic [DW-1:0] arg_src,
    output logic          rst_pulse,
    output logic          clr_rst,
    output logic [DW-1:0] boot_addr,
    output logic [DW-1:0] boot_arg
);
    seq_state_t state_q, state_d;
    logic       pulse_d;
    logic       any_req;

    assign any_req = req_rst || req_pwr;

    always_comb begin
        state_d = state_q;
        pulse_d = 1'b0;
        clr_rst = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (any_req) state_d = SEQ_WAIT;
                pulse_d = req_rst;
            end
            SEQ_WAIT: begin
                if (ack) begin
                    pulse_d = req_rst;
                    if (!any_req) begin
                        state_d = SEQ_IDLE;
                        clr_rst = 1'b1;
                    end
                end else if (req_rst) begin
                    state_d = SEQ_WAIT_PEND;
                end
            end
            SEQ_WAIT_PEND: begin
                if (ack) begin
                    state_d = SEQ_WAIT;
                    pulse_d = 1'b1;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_pulse <= 1'b0;
            boot_addr <= '0;
            boot_arg  <= '0;
        end else begin
            rst_pulse <= pulse_d;
            if (req_pwr && pwr_on) begin
                boot_addr <= addr_src;
                boot_arg  <= arg_src;
            end
        end
    end

endmodule

// File: rtl/rbc_top.sv
module rbc_top #(
    parameter int DW     = 32,
    parameter int AW     = 12,
    parameter int NCORES = 4,
    parameter int NREGS  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [AW-1:0]        bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    output logic                 bus_err,
    input  logic [NCORES-1:0]    core_ack,
    output logic [NCORES-1:0]    core_en,
    output logic [NCORES-1:0]    core_rst,
    output logic [NCORES*DW-1:0] core_boot_addr,
    output logic [NCORES*DW-1:0] core_boot_arg,
    output logic [1:0]           aux_rst
);
    logic [NCORES-1:0]    rst_clr;
    logic [NCORES-1:0]    rst_chg;
    logic [NCORES-1:0]    en_chg;
    logic [NCORES-1:0]    en_wval;
    logic [NCORES*DW-1:0] src_addr;
    logic [NCORES*DW-1:0] src_arg;

    rbc_regfile #(
        .DW(DW), .AW(AW), .NREGS(NREGS), .NCORES(NCORES)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .rst_clr   (rst_clr),
        .rst_chg   (rst_chg),
        .en_chg    (en_chg),
        .en_wval   (en_wval),
        .en_q      (core_en),
        .src_addr  (src_addr),
        .src_arg   (src_arg),
        .aux_pulse (aux_rst)
    );

    generate
        for (genvar k = 0; k < NCORES; k++) begin : g_seq
            rbc_core_seq #(.DW(DW)) u_seq (
                .clk       (clk),
                .rst_n     (rst_n),
                .req_rst   (rst_chg[k]),
                .req_pwr   (en_chg[k]),
                .pwr_on    (en_wval[k]),
                .ack       (core_ack[k]),
                .addr_src  (src_addr[k*DW +: DW]),
                .arg_src   (src_arg[k*DW +: DW]),
                .rst_pulse (core_rst[k]),
                .clr_rst   (rst_clr[k]),
                .boot_addr (core_boot_addr[k*DW +: DW]),
                .boot_arg  (core_boot_arg[k*DW +: DW])
            );
        end
    endgenerate

endmodule

// File: rtl/rbc_checker.sv
module rbc_checker #(
    parameter int DW       = 32,
    parameter int AW       = 12,
    parameter int NCORES   = 4,
    parameter int NREGS    = 16,
    parameter int RST_LSB  = 13,
    parameter int AUX0_BIT = 3,
    parameter int AUX1_BIT = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_sel,
    input logic                 bus_wr,
    input logic [AW-1:0]        bus_addr,
    input logic [DW-1:0]        bus_wdata,
    input logic [DW-1:0]        bus_rdata,
    input logic                 bus_err,
    input logic [NCORES-1:0]    core_ack,
    input logic [NCORES-1:0]    core_rst,
    input logic [NCORES*DW-1:0] core_boot_addr,
    input logic [1:0]           aux_rst
);
    logic ctrl_wr_w;
    logic at_ctrl;
    assign at_ctrl   = (bus_addr == '0);
    assign ctrl_wr_w = bus_sel && bus_wr && at_ctrl;

    a_r3_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_sel) &&
                    (($past(32'(bus_addr[AW-1:2])) >= NREGS) || ($past(bus_addr[1:0]) != 2'b00)));

    a_r4_aux_never_stored: assert property (@(posedge clk) disable iff (!rst_n)
        at_ctrl |-> !bus_rdata[AUX0_BIT] && !bus_rdata[AUX1_BIT]);

    a_r4_aux_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        aux_rst[0] |-> $past(ctrl_wr_w) && $past(bus_wdata[AUX0_BIT]));

    generate
        for (genvar k = 0; k < NCORES; k++) begin : g_chk
            a_r7_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
                core_rst[k] |-> $past(ctrl_wr_w) || $past(core_ack[k]));

            a_r8_clear_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
                (at_ctrl && $past(at_ctrl) && $fell(bus_rdata[RST_LSB+k]))
                    |-> $past(core_ack[k]) || $past(ctrl_wr_w));

            a_r5_boot_latch_on_write: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(core_boot_addr[k*DW +: DW]) |-> $past(ctrl_wr_w));
        end
    endgenerate

endmodule

bind rbc_top rbc_checker #(.DW(DW), .AW(AW), .NCORES(NCORES), .NREGS(NREGS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_sel        (bus_sel),
    .bus_wr         (bus_wr),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .bus_err        (bus_err),
    .core_ack       (core_ack),
    .core_rst       (core_rst),
    .core_boot_addr (core_boot_addr),
    .aux_rst        (aux_rst)
);

// File: tb/rbc_top_tb_top.sv
`timescale 1ns/1ps
module rbc_top_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0;
    logic         bus_wr = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         bus_err;
    logic [3:0]   core_ack = '0;
    logic [3:0]   core_en;
    logic [3:0]   core_rst;
    logic [127:0] core_boot_addr;
    logic [127:0] core_boot_arg;
    logic [1:0]   aux_rst;

    int errors = 0;
    int checks = 0;
    logic [31:0] c;
    logic [31:0] d;

    always #4 clk = ~clk;

    rbc_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .core_ack(core_ack), .core_en(core_en),
        .core_rst(core_rst), .core_boot_addr(core_boot_addr),
        .core_boot_arg(core_boot_arg), .aux_rst(aux_rst)
    );

    function automatic logic [31:0] pat(int i);
        return 32'h1000_0000 + 32'(i) * 32'h0001_0203;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int idx, logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'(idx * 4); bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr_raw(logic [11:0] a, logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(int idx, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 12'(idx * 4);
        #1 v = bus_rdata;
    endtask

    task automatic ack(int k);
        @(negedge clk);
        core_ack[k] = 1'b1;
        @(negedge clk);
        core_ack[k] = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        for (int i = 0; i < 16; i++) begin
            rd(i, d);
            chk("R1", d, (i == 0) ? 32'h521 : (i == 2) ? 32'h1 : (i == 4) ? 32'h1F : 32'h0);
        end
        chk("R10 core0 en", {28'd0, core_en}, 32'h1);
        chk("R1 no pulses", {26'd0, aux_rst, core_rst}, 32'h0);

        // R2 storage sweep
        for (int i = 1; i < 16; i++) wr(i, pat(i));
        for (int i = 1; i < 16; i++) begin
            rd(i, d);
            chk("R2", d, pat(i));
        end

        // R3 out of range and misaligned
        for (int j = 0; j < 4; j++) begin
            int bad = (j == 0) ? 16 : (j == 1) ? 17 : (j == 2) ? 255 : 1023;
            wr(bad, 32'hFFFF_FFFF);
            chk("R3 err", {31'd0, bus_err}, 32'h1);
            @(negedge clk);
            chk("R3 err one cycle", {31'd0, bus_err}, 32'h0);
            rd(bad, d);
            chk("R3 reads zero", d, 32'h0);
        end
        wr_raw(12'h019, 32'hDEAD_BEEF);
        chk("R3 misaligned err", {31'd0, bus_err}, 32'h1);
        rd(6, d);
        chk("R3 no change", d, pat(6));
        rd(0, d);
        chk("R3 ctrl intact", d, 32'h521);

        // R4 auxiliary resets
        c = 32'h521;
        wr(0, c | 32'h8);
        chk("R4 aux0 pulse", {30'd0, aux_rst}, 32'h1);
        @(negedge clk);
        chk("R4 aux0 ends", {30'd0, aux_rst}, 32'h0);
        wr(0, c | 32'h1000);
        chk("R4 aux1 pulse", {30'd0, aux_rst}, 32'h2);
        rd(0, d);
        chk("R4 not stored", d, c);

        // R10 plain storage bits
        wr(0, c | 32'h8000_0002);
        chk("R10 no action", {28'd0, core_rst}, 32'h0);
        chk("R10 en unchanged", {28'd0, core_en}, 32'h1);
        rd(0, d);
        chk("R10 stored", d, c | 32'h8000_0002);
        wr(0, c);

        // R5 power-on with boot latch
        for (int k = 1; k < 4; k++) begin
            c = c | (32'h1 << (21 + k));
            wr(0, c);
            chk("R5 en", 32'(core_en[k]), 32'h1);
            chk("R5 no rst pulse", {28'd0, core_rst}, 32'h0);
            chk("R5 addr", core_boot_addr[k*32 +: 32], pat(6 + 2*k));
            chk("R5 arg", core_boot_arg[k*32 +: 32], pat(7 + 2*k));
            ack(k);
            wr(6 + 2*k, 32'hCAFE_0000 + 32'(k));
            chk("R5 latched hold", core_boot_addr[k*32 +: 32], pat(6 + 2*k));
        end

        // R7/R8 reset per core, held until acknowledge
        for (int k = 0; k < 4; k++) begin
            c = c | (32'h1 << (13 + k));
            wr(0, c);
            chk("R7 pulse", {28'd0, core_rst}, 32'h1 << k);
            @(negedge clk);
            chk("R7 one cycle", {28'd0, core_rst}, 32'h0);
            repeat (3) @(negedge clk);
            rd(0, d);
            chk("R8 held", d, c);
            ack(k);
            c = c & ~(32'h1 << (13 + k));
            rd(0, d);
            chk("R8 cleared", d, c);
            chk("R8 no pulse on ack", {28'd0, core_rst}, 32'h0);
        end
        ack(0);
        rd(0, d);
        chk("R8 idle ack ignored", d, c);

        // R9 request during wait is deferred
        c = c | 32'h8000;
        wr(0, c);
        chk("R9 first pulse", {28'd0, core_rst}, 32'h4);
        c = c & ~32'h8000;
        wr(0, c);
        chk("R9 no pulse while waiting", {28'd0, core_rst}, 32'h0);
        ack(2);
        chk("R9 replay pulse", {28'd0, core_rst}, 32'h4);
        c = c | 32'h8000;
        wr(0, c);
        rd(0, d);
        chk("R9 bit still set", d, c);
        ack(2);
        ack(2);
        c = c & ~32'h8000;
        rd(0, d);
        chk("R9 cleared after final ack", d, c);

        // R6 power-off, combined with a reset request on core 1
        c = (c & ~32'h0040_0000) | 32'h4000;
        wr(0, c);
        chk("R6 en off", 32'(core_en[1]), 32'h0);
        chk("R6 reset pulse from rst bit", {28'd0, core_rst}, 32'h2);
        ack(1);
        c = c & ~32'h4000;
        rd(0, d);
        chk("R8 cleared after enable change", d, c);
        c = c & ~32'h0100_0000;
        wr(0, c);
        chk("R6 en3 off", {28'd0, core_en}, 32'h5);
        chk("R6 no pulse", {28'd0, core_rst}, 32'h0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule